// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a simple synchronous host port and a byte-wide asynchronous static RAM with a 19-bit address and an 8-bit data path. The host raises a one-cycle request with a direction, an address and a write byte. The controller turns that request into active-low chip-enable, output-enable and write-enable sequences. All timing is counted in clock cycles: the read access window, the write pulse width and the recovery gap after a write are parameters.

The controller is built around one state machine. PH_IDLE accepts a request and goes to PH_SETUP, where only the address is presented. A read then enters PH_RD_ACC, holding chip-enable and output-enable low for T_ACC cycles, and samples the bus on the last edge. A write enters PH_WR_OPEN, where chip-enable and write-enable fall together and the bus is still released. It then enters PH_WR_DRIVE, where the write byte is driven for T_WP-1 cycles. Both paths release every strobe in PH_HOLD, which keeps the address one more cycle. A read returns from PH_HOLD to PH_IDLE. A write passes through PH_RECOV for T_REC cycles before it returns.

A request made while the controller is busy is dropped. A write-inhibit input makes the controller refuse new writes, so that a failing supply cannot corrupt the memory. Reads are still served.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, busy and rvalid are low, all three strobes are high (inactive) and the data bus enable is low.
- R2: A read raises chip-enable and output-enable low together for exactly T_ACC cycles with write-enable high. The byte on the bus at the last of those clock edges is returned as read data.
- R3: A read keeps busy high for T_ACC+2 cycles. rvalid pulses high for exactly one cycle within that window, together with the read byte.
- R4: A write holds chip-enable and write-enable low together for exactly T_WP cycles. Output-enable stays high for the whole write, and output-enable is never low while write-enable is low.
- R5: The data bus enable is high only while write-enable is low and was also low in the previous cycle. In every other cycle the bus is released.
- R6: After write-enable rises, no strobe falls again for at least T_REC+1 cycles. A write keeps busy high for T_WP+T_REC+2 cycles.
- R7: The address changes only while all strobes are high, and never in the cycle after any strobe was low. It is therefore stable one cycle before, during and one cycle after every strobe window.
- R8: A request seen while busy is high is ignored and not queued. Memory contents and later transfers are unaffected by it.
- R9: While write-inhibit is high, a write request in idle is ignored: busy stays low and write-enable stays high. A read request is still served, and a write already under way finishes.
- R10: A byte written to an address is returned by a later read of that address, at both ends of the 19-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host transfer request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| wr_inhibit | input | 1 | Refuse new write requests while high |
| busy | output | 1 | Transfer in progress; requests are ignored |
| rdata | output | 8 | Read byte, valid with rvalid |
| rvalid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | 8 | Data received from memory |

## Verification
Suppose the state machine leaves a timed phase one cycle early or late. This shows up at once as a strobe window of the wrong length, counted at the memory pins on the cycle write-enable rises or busy falls. It also shows up as a byte sampled before the memory model's access window has closed, which is seen when rvalid fires. A wrong address or data register may not be visible when it happens. It shows up when a later read of the affected address returns a byte different from the reference copy the bench keeps. Bus enable or output-enable asserted in the wrong phase is flagged in the very cycle it occurs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_RD_ACC,
        PH_WR_OPEN,
        PH_WR_DRIVE,
        PH_HOLD,
        PH_RECOV
    } phase_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int T_ACC = 4,
    parameter int T_WP  = 3,
    parameter int T_REC = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             wr_inhibit,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             busy,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(T_ACC - 1);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(T_WP - 2);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(T_REC - 1);

    phase_t state_q, state_d;
    logic   op_wr_q;

    // state register and operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            op_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_wr_q <= req_we;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        busy     = 1'b1;
        ce_n     = 1'b1;
        oe_n     = 1'b1;
        we_n     = 1'b1;
        dq_oe    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                busy = 1'b0;
                if (req && !(req_we && wr_inhibit)) begin
                    accept  = 1'b1;
                    state_d = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (op_wr_q) begin
                    state_d = PH_WR_OPEN;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACC;
                    state_d  = PH_RD_ACC;
                end
            end
            PH_RD_ACC: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
                if (tmr_zero) begin
                    capture = 1'b1;
                    state_d = PH_HOLD;
                end
            end
            PH_WR_OPEN: begin
                ce_n     = 1'b0;
                we_n     = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = LD_WP;
                state_d  = PH_WR_DRIVE;
            end
            PH_WR_DRIVE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
                if (tmr_zero) begin
                    state_d = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (op_wr_q && (T_REC != 0)) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_REC;
                    state_d  = PH_RECOV;
                end else begin
                    state_d = PH_IDLE;
                end
            end
            PH_RECOV: begin
                if (tmr_zero) begin
                    state_d = PH_IDLE;
                end
            end
            default: begin
                state_d = PH_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int T_ACC  = 4,
    parameter int T_WP   = 3,
    parameter int T_REC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wr_inhibit,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int MAX_AW = (T_ACC > T_WP) ? T_ACC : T_WP;
    localparam int MAX_T  = (MAX_AW > T_REC) ? MAX_AW : T_REC;
    localparam int CNT_W  = (MAX_T < 2) ? 1 : $clog2(MAX_T);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_strobe_fsm #(
        .T_ACC (T_ACC),
        .T_WP  (T_WP),
        .T_REC (T_REC),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .wr_inhibit (wr_inhibit),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture),
        .busy       (busy),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_oe      (mem_dq_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_dq_i;
            end
            rvalid_q <= capture;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rdata    = rdata_q;
    assign rvalid   = rvalid_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              req_we,
    input logic              wr_inhibit,
    input logic              busy,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    a_r2_no_read_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    a_r4_write_keeps_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    a_r5_bus_after_we_fall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !$past(mem_we_n)));

    a_r3_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    a_r6_recovery_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> (mem_we_n && mem_ce_n && busy));

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_ce_n) |-> $stable(mem_addr));

    a_r9_inhibit_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && req_we && wr_inhibit) |=> !busy);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .wr_inhibit (wr_inhibit),
    .busy       (busy),
    .rvalid     (rvalid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

    localparam int AW    = 19;
    localparam int DW    = 8;
    localparam int T_ACC = 4;
    localparam int T_WP  = 3;
    localparam int T_REC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          wr_inhibit = 1'b0;
    logic          busy;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_WP(T_WP), .T_REC(T_REC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .wr_inhibit(wr_inhibit),
        .busy(busy), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: data valid only once the access window has elapsed
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] model_q = '0;
    int            acc_cnt = 0;

    function automatic logic [DW-1:0] exp_byte(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    assign mem_dq_i = (!mem_ce_n && !mem_oe_n && acc_cnt >= T_ACC) ? model_q : 8'hEE;

    // pin monitor
    bit            prev_any = 1'b0;
    bit            prev_we_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    int            we_run = 0;
    int            gap = 0;
    bit            gap_on = 1'b0;

    always @(negedge clk) begin
        bit any_lo;
        if (rst_n) begin
            any_lo = !mem_ce_n || !mem_oe_n || !mem_we_n;
            acc_cnt = (!mem_ce_n && !mem_oe_n) ? acc_cnt + 1 : 0;
            model_q = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
            if (!mem_ce_n && !mem_we_n && mem_dq_oe)
                model_mem[int'(mem_addr)] = mem_dq_o;
            if (any_lo && !prev_any)
                chk(mem_addr == prev_addr, "R7 address set up before strobes", int'(mem_addr), int'(prev_addr));
            if (prev_any)
                chk(mem_addr == prev_addr, "R7 address held", int'(mem_addr), int'(prev_addr));
            if (!mem_oe_n)
                chk(mem_we_n, "R4 oe low during write", 0, 1);
            if (mem_dq_oe)
                chk(!mem_we_n && !prev_we_n, "R5 bus driven outside pulse", int'(prev_we_n), 0);
            if (gap_on && any_lo) begin
                chk(gap >= T_REC + 1, "R6 recovery gap", gap, T_REC + 1);
                gap_on = 1'b0;
            end else if (gap_on) begin
                gap++;
            end
            if (!mem_we_n) begin
                we_run++;
            end else if (!prev_we_n) begin
                chk(we_run == T_WP, "R4 write pulse width", we_run, T_WP);
                we_run = 0;
                gap = 1;
                gap_on = 1'b1;
            end
            prev_any  = any_lo;
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
        end
    end

    task automatic host_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output int cyc, output int rv, output logic [DW-1:0] rd);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        cyc = 0; rv = 0; rd = '0;
        while (busy && cyc < 100) begin
            cyc++;
            if (rvalid) begin rv++; rd = rdata; end
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int cyc, rv;
        logic [DW-1:0] rd;
        host_op(1'b1, a, d, cyc, rv, rd);
        chk(cyc == T_WP + T_REC + 2, "R6 write busy length", cyc, T_WP + T_REC + 2);
        chk(rv == 0, "R3 no rvalid on write", rv, 0);
        ref_mem[int'(a)] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        int cyc, rv;
        logic [DW-1:0] rd;
        host_op(1'b0, a, '0, cyc, rv, rd);
        chk(cyc == T_ACC + 2, "R3 read busy length", cyc, T_ACC + 2);
        chk(rv == 1, "R3 single rvalid", rv, 1);
        chk(rd == exp_byte(int'(a)), tag, int'(rd), int'(exp_byte(int'(a))));
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0019));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !rvalid, "R1 busy/rvalid in reset", {busy, rvalid}, 0);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe, "R1 bus released in reset", mem_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && mem_ce_n && mem_oe_n && mem_we_n, "R1 idle after reset", busy, 0);

        // R10: address range ends
        do_write(19'h00000, 8'hA5);
        do_write(19'h7FFFF, 8'h5A);
        do_read(19'h00000, "R10 low end readback");
        do_read(19'h7FFFF, "R10 high end readback");
        do_read(19'h12345, "R2 unwritten location");

        // R8: request while busy is dropped
        begin
            req = 1'b1; req_we = 1'b0; req_addr = 19'h00000;
            @(negedge clk);
            req_we = 1'b1; req_addr = 19'h00000; req_wdata = 8'hFF;
            repeat (3) @(negedge clk);
            req = 1'b0;
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(!busy && mem_we_n, "R8 no queued write", busy, 0);
            do_read(19'h00000, "R8 contents unchanged");
        end

        // R9: inhibit refuses writes, keeps reads
        wr_inhibit = 1'b1;
        req = 1'b1; req_we = 1'b1; req_addr = 19'h7FFFF; req_wdata = 8'h77;
        @(negedge clk);
        req = 1'b0;
        chk(!busy && mem_we_n, "R9 write refused", busy, 0);
        @(negedge clk);
        chk(!busy, "R9 still idle", busy, 0);
        do_read(19'h7FFFF, "R9 read served under inhibit");
        wr_inhibit = 1'b0;

        // R9: inhibit rising during a write lets it finish
        begin
            int cyc = 0;
            req = 1'b1; req_we = 1'b1; req_addr = 19'h00ABC; req_wdata = 8'h3C;
            @(negedge clk);
            req = 1'b0;
            wr_inhibit = 1'b1;
            while (busy && cyc < 100) begin cyc++; @(negedge clk); end
            chk(cyc == T_WP + T_REC + 2, "R9 started write finishes", cyc, T_WP + T_REC + 2);
            ref_mem[32'h00ABC] = 8'h3C;
            wr_inhibit = 1'b0;
            do_read(19'h00ABC, "R9 started write landed");
        end

        // random mix
        for (int i = 0; i < 120; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = {3'($urandom_range(0, 7)), 12'h0, 4'($urandom)};
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a, "R2 random read data");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule